// File: doc/BRIEF.md
# Address-Programmable Digital Delay Line

This block is a clocked model of a delay line whose length is chosen by a 6-bit code. A single-bit input is sampled on every rising clock edge. The same value comes out later, after a number of cycles set by the code. The delay is a fixed base offset plus the code times a per-step increment. Both the base and the step are parameters given in clock cycles.

Two outputs are driven: a true copy of the delayed input and its complement. Two active-low enable pins are combined into one enable. When the block is disabled, the outputs go straight to fixed idle levels. The shift chain keeps running while the outputs are forced.

The code is never held in a register. It steers the tap multiplexer directly, so a new code picks a different tap at once. The code must therefore stay steady while the block is in use, and it must be in place at least one cycle before any input edge that should see the new delay.

Top module: `pdl_delay_line`

## Requirements
- R1: The code `addr` is 6 bits wide, which gives 64 settings. A larger code always gives a strictly longer delay.
- R2: With delay D = BASE_DLY + STEP_DLY*addr, the value `dout` shows after rising edge n equals the value of `din` sampled at rising edge n−D+1. Edges are counted from the first edge after reset is released.
- R3: While the block is enabled, `dout_n` is always the logical inverse of `dout`.
- R4: The block counts as disabled when either `en_a_n` or `en_b_n` is 1, including when the two pins disagree. It is enabled only when both are 0.
- R5: While disabled, `dout` is 0 and `dout_n` is 1 in the same cycle, with no clock edge needed.
- R6: Disabling does not stall the shift chain. In the first cycle after re-enabling, the outputs again follow the R2 relation, including for samples taken while disabled.
- R7: The code is not registered. A change of `addr` between edges changes the selected tap, and so the outputs, without waiting for a clock edge.
- R8: A synchronous active-high `rst` clears every stage to 0. Until real input samples reach the selected tap, `dout` reads 0 and `dout_n` reads 1 while enabled.
- R9: The chain holds BASE_DLY + 63*STEP_DLY stages, with BASE_DLY ≥ 1 and STEP_DLY ≥ 1. At code 63 the output reproduces an input sampled that many edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, clears the chain |
| din | input | 1 | Signal to be delayed |
| addr | input | 6 | Delay code, used live |
| en_a_n | input | 1 | Active-low enable, first pin |
| en_b_n | input | 1 | Active-low enable, second pin |
| dout | output | 1 | Delayed true output, forced 0 when disabled |
| dout_n | output | 1 | Delayed complement output, forced 1 when disabled |

## Verification
A wrong stage in the chain shows up as a wrong `dout` bit exactly when that stage is selected. A broken shift shows up one edge later at every code that lies beyond it. For this reason the bench steps through all 64 codes and holds each one longer than its own delay. A wrong tap index or step scaling shows up as a shift by whole cycles against the bench's arithmetic history. It is seen in the very cycle the code is applied, because the tap choice is combinational. Faults in the enable or complement path are visible in the same cycle at both outputs. The enable faults are exercised with random pin pairs, including pairs where the two pins disagree.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    localparam int ADDR_W = 6;
    localparam int STEPS  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] pdl_code_t;

    typedef enum logic {
        PATH_LIVE   = 1'b0,
        PATH_FORCED = 1'b1
    } pdl_path_e;

    typedef struct packed {
        logic true_o;
        logic comp_o;
    } pdl_out_t;

    // Number of chain stages needed to reach the longest setting.
    function automatic int chain_depth(input int base_dly, input int step_dly);
        return base_dly + (STEPS - 1) * step_dly;
    endfunction

endpackage

// File: rtl/pdl_tap_chain.sv
module pdl_tap_chain #(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    // Stage 0 takes the input; stage s holds the sample from s edges back.
    always_ff @(posedge clk) begin
        if (rst) taps <= '0;
        else     taps <= {taps[DEPTH-2:0], din};
    end

    AST_CHAIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (taps[DEPTH-1:1] == $past(taps[DEPTH-2:0]))); // R2

endmodule

// File: rtl/pdl_tap_select.sv
module pdl_tap_select
    import pdl_pkg::*;
#(
    parameter int BASE_DLY = 1,
    parameter int STEP_DLY = 1,
    parameter int DEPTH    = chain_depth(BASE_DLY, STEP_DLY)
) (
    input  logic             clk,
    input  logic             rst,
    input  pdl_code_t        code,
    input  logic [DEPTH-1:0] taps,
    output logic             picked
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] tap_idx;

    // A delay of D cycles reads stage D-1; the code feeds the mux directly.
    always_comb begin
        tap_idx = IDX_W'(BASE_DLY - 1) + IDX_W'(STEP_DLY) * IDX_W'(code);
        picked  = taps[tap_idx];
    end

    AST_MONOTONIC_TAP: assert property (@(posedge clk) disable iff (rst)
        ($past(code) < code) |-> (tap_idx > $past(tap_idx))); // R1

endmodule

// File: rtl/pdl_out_stage.sv
module pdl_out_stage
    import pdl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_a_n,
    input  logic     en_b_n,
    input  logic     tap_bit,
    output pdl_out_t outs
);

    pdl_path_e path;

    always_comb begin
        path = (en_a_n || en_b_n) ? PATH_FORCED : PATH_LIVE;
        case (path)
            PATH_LIVE:   outs = '{true_o: tap_bit, comp_o: ~tap_bit};
            default:     outs = '{true_o: 1'b0,    comp_o: 1'b1};
        endcase
    end

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_LIVE) |-> (outs.true_o != outs.comp_o)); // R3

endmodule

// File: rtl/pdl_delay_line.sv
module pdl_delay_line
    import pdl_pkg::*;
#(
    parameter int BASE_DLY = 2,
    parameter int STEP_DLY = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_a_n,
    input  logic              en_b_n,
    output logic              dout,
    output logic              dout_n
);

    localparam int DEPTH = chain_depth(BASE_DLY, STEP_DLY);

    logic [DEPTH-1:0] taps;
    logic             picked;
    pdl_out_t         outs;

    pdl_tap_chain #(.DEPTH(DEPTH)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .taps (taps)
    );

    pdl_tap_select #(
        .BASE_DLY (BASE_DLY),
        .STEP_DLY (STEP_DLY),
        .DEPTH    (DEPTH)
    ) u_select (
        .clk    (clk),
        .rst    (rst),
        .code   (addr),
        .taps   (taps),
        .picked (picked)
    );

    pdl_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .en_a_n  (en_a_n),
        .en_b_n  (en_b_n),
        .tap_bit (picked),
        .outs    (outs)
    );

    assign dout   = outs.true_o;
    assign dout_n = outs.comp_o;

    AST_FORCED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (en_a_n || en_b_n) |-> (!dout && dout_n)); // R5

endmodule

// File: tb/sim_pdl_delay_line.sv
`timescale 1ns/1ps
module sim_pdl_delay_line;

    localparam int BASE_DLY = 3;
    localparam int STEP_DLY = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       din;
    logic [5:0] addr;
    logic       en_a_n;
    logic       en_b_n;
    logic       dout;
    logic       dout_n;

    always #10 clk = ~clk;

    pdl_delay_line #(.BASE_DLY(BASE_DLY), .STEP_DLY(STEP_DLY)) u0 (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .addr   (addr),
        .en_a_n (en_a_n),
        .en_b_n (en_b_n),
        .dout   (dout),
        .dout_n (dout_n)
    );

    int n;
    bit hist [16384];
    int checks;
    int fails;
    bit done;

    function automatic bit exp_bit(int code);
        int idx;
        idx = n - (BASE_DLY + STEP_DLY * code) + 1;
        return (idx >= 1) ? hist[idx] : 1'b0;
    endfunction

    task automatic check_ports(string tag);
        logic et, ec;
        if (en_a_n || en_b_n) begin
            et = 1'b0; ec = 1'b1;
        end else begin
            et = exp_bit(int'(addr)); ec = ~et;
        end
        checks++;
        if (dout !== et || dout_n !== ec) begin
            fails++;
            $display("FAIL %s: n=%0d addr=%0d dout=%b dout_n=%b expected %b %b",
                     tag, n, addr, dout, dout_n, et, ec);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) n = 0;
        else begin
            n++;
            hist[n] = din;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        bit was_off;
        rst = 1'b1; din = 1'b0; addr = '0; en_a_n = 1'b0; en_b_n = 1'b0;
        n = 0; checks = 0; fails = 0; done = 1'b0;
        repeat (3) tick();
        check_ports("R8 reset state");
        rst = 1'b0;

        // R8: ones enter, long tap still shows cleared stages
        addr = 6'd63; din = 1'b1;
        repeat (20) begin tick(); check_ports("R8 cleared chain"); end

        // Sweep of every code, each held longer than its delay
        for (int a = 0; a < 64; a++) begin
            addr = 6'(a);
            #1 check_ports(a == 63 ? "R9 R7 code switch" : "R7 code switch");
            repeat (BASE_DLY + STEP_DLY * a + 4) begin
                din = 1'($urandom);
                tick();
                check_ports(a == 63 ? "R9 R1 R2 R3" : "R1 R2 R3");
            end
        end

        // Random enable pairs and live code changes
        was_off = 1'b0;
        repeat (400) begin
            if ($urandom % 8 == 0) addr = 6'($urandom);
            en_a_n = ($urandom % 4 == 0);
            en_b_n = ($urandom % 4 == 0);
            din    = 1'($urandom);
            tick();
            if (en_a_n || en_b_n) check_ports("R4 R5 disabled");
            else if (was_off)     check_ports("R6 resume");
            else                  check_ports("R2 R3 random");
            was_off = en_a_n || en_b_n;
        end
        en_a_n = 1'b0; en_b_n = 1'b0;

        // Mid-run reset
        din = 1'b1;
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        addr = 6'd40;
        repeat (100) begin tick(); check_ports("R8 after mid reset"); end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

endmodule